// File: doc/BRIEF.md
# Address-Window Instruction Memory

This block sits where an instruction cache would sit in front of a fetch unit. It holds a fixed on-chip RAM and keeps no tags. Whether a fetch hits is decided only by its address. A fetch whose address lies inside one aligned window (base plus size) is read from the local RAM with zero wait states. Every other fetch is sent to an external bus and waits for that bus to acknowledge.

The fetch side works one request at a time:

- The requester raises `fetch_req` with an address.
- It holds both until it sees `fetch_ready`.
- In the cycle where `fetch_ready` is high it may present its next request.
- An in-window fetch presented in cycle t completes with `fetch_ready` in cycle t+1. Back-to-back in-window fetches therefore complete one per cycle.

A load port writes whole words into the RAM before execution, and while it is active every new fetch stalls. The window size is a parameter and can be set large enough to hold a whole program, for example 512 KB. The base must be a multiple of the size, so that the window test compares only the upper address bits.

Top module: `fixed_imem`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `fetch_ready` and `bus_req` are low.
- R2: A fetch accepted while idle with `load_en` low is in the window when `fetch_addr[ADDR_W-1:log2(MEM_BYTES)]` equals the same bits of `BASE_ADDR`. Such a fetch gives `fetch_ready` high in the next cycle, with `fetch_data` equal to RAM word `fetch_addr[log2(MEM_BYTES)-1:log2(DATA_W/8)]`. A new in-window fetch may be accepted in every cycle.
- R3: An in-window fetch never raises `bus_req`.
- R4: An out-of-window fetch accepted while idle raises `bus_req` in the next cycle, with `bus_addr` equal to the fetch address. Both are held, with `fetch_ready` low, until a cycle in which `bus_ack` is high.
- R5: After a cycle with `bus_req` and `bus_ack` both high, the next cycle has `fetch_ready` high, `fetch_data` equal to the `bus_data` sampled with the acknowledge, and `bus_req` low.
- R6: At each clock edge with `load_en` high, `load_data` is written to RAM word `load_addr`. A later in-window fetch of that word returns the value written last.
- R7: A fetch presented while the block is idle and `load_en` is high is not accepted. It produces neither `fetch_ready` nor `bus_req` until `load_en` falls, and it is then served normally.
- R8: The byte-offset bits `fetch_addr[log2(DATA_W/8)-1:0]` have no effect on which word is returned.
- R9: While a bus fetch is outstanding, changes on `fetch_req` and `fetch_addr` do not alter `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch request, held until `fetch_ready` |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_data | output | DATA_W | Instruction word, valid while `fetch_ready` is high |
| fetch_ready | output | 1 | Completion of the pending fetch |
| bus_req | output | 1 | External bus request for out-of-window fetches |
| bus_addr | output | ADDR_W | Address sent to the external bus |
| bus_ack | input | 1 | External bus acknowledge |
| bus_data | input | DATA_W | External bus read data |
| load_en | input | 1 | Load port write enable; stalls new fetches |
| load_addr | input | log2(MEM_BYTES/(DATA_W/8)) | Word index written by the load port |
| load_data | input | DATA_W | Word written by the load port |

## Verification
The bench builds the block with a 16-bit address, 32-bit words, a 256-byte window (64 words) and a base of 0x0400. With this window it can load every word and fetch every word back-to-back, using a different byte offset on each fetch. It can also probe the addresses just below and just above the window edges, and the extremes of the address space, with bus latencies from zero to three wait cycles. Expected RAM and bus words come from arithmetic functions of the index or address, so every word is distinct. This makes a wrong index, a stale register or a swapped data source visible, and the load-stall cases can be reached for both an in-window and an out-of-window fetch.

// File: rtl/fim_pkg.sv
package fim_pkg;

    // Controller state: idle (accepting) or waiting on the external bus
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } fim_state_e;

    // Where the word returned to the fetch unit comes from
    typedef enum logic [0:0] {
        SRC_RAM = 1'b0,
        SRC_BUS = 1'b1
    } fim_src_e;

    // Registered response toward the fetch unit
    typedef struct packed {
        logic     ready;
        fim_src_e src;
    } fim_resp_t;

    localparam fim_resp_t FIM_RESP_IDLE = '{ready: 1'b0, src: SRC_RAM};

    // Number of byte-offset bits for a word of the given width
    function automatic int unsigned fim_ofs_bits(input int unsigned data_w);
        return $clog2(data_w / 8);
    endfunction

    // Number of word-index bits for a window of the given size
    function automatic int unsigned fim_idx_bits(input int unsigned mem_bytes,
                                                 input int unsigned data_w);
        return $clog2(mem_bytes / (data_w / 8));
    endfunction

endpackage

// File: rtl/fim_range_check.sv
module fim_range_check #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned WIN_AW   = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range
);
    localparam int unsigned HI_W = ADDR_W - WIN_AW;
    localparam logic [HI_W-1:0] BASE_HI = BASE_ADDR[ADDR_W-1:WIN_AW];

    // Bits below the window size select within the window and never affect the test
    logic unused_low;
    assign unused_low = ^addr[WIN_AW-1:0];

    assign in_range = (addr[ADDR_W-1:WIN_AW] == BASE_HI);

endmodule

// File: rtl/fim_ram.sv
module fim_ram #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 1024,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Write and read ports; the read register holds its value between reads
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= mem[rd_idx];
        end
    end

endmodule

// File: rtl/fim_ctrl.sv
module fim_ctrl
    import fim_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              in_range,
    input  logic              load_busy,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_data,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              rd_en,
    output fim_resp_t         resp,
    output logic [DATA_W-1:0] bus_word
);
    fim_state_e state_q;
    logic       accept;
    logic       miss_go;

    // A new request is taken only while idle and with the loader quiet
    assign accept  = (state_q == ST_IDLE) && fetch_req && !load_busy;
    assign rd_en   = accept && in_range;
    assign miss_go = accept && !in_range;
    assign bus_req = (state_q == ST_BUS);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            resp     <= FIM_RESP_IDLE;
            bus_addr <= '0;
            bus_word <= '0;
        end else begin
            resp.ready <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (rd_en) begin
                        resp <= '{ready: 1'b1, src: SRC_RAM};
                    end else if (miss_go) begin
                        state_q  <= ST_BUS;
                        bus_addr <= fetch_addr;
                    end
                end
                ST_BUS: begin
                    if (bus_ack) begin
                        state_q  <= ST_IDLE;
                        resp     <= '{ready: 1'b1, src: SRC_BUS};
                        bus_word <= bus_data;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        (!bus_req && fetch_req && in_range && !load_busy) |=> !bus_req) else $error("AST_HIT_NO_BUS"); // R3

    AST_MISS_REQ: assert property (@(posedge clk) disable iff (rst)
        (!bus_req && fetch_req && !in_range && !load_busy) |=> (bus_req && bus_addr == $past(fetch_addr))) else $error("AST_MISS_REQ"); // R4

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && !resp.ready)) else $error("AST_BUS_HOLD"); // R9

    AST_ACK_READY: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ack) |=> (resp.ready && !bus_req && bus_word == $past(bus_data))) else $error("AST_ACK_READY"); // R5

    AST_LOAD_STALL: assert property (@(posedge clk) disable iff (rst)
        (load_busy && !bus_req) |=> (!resp.ready && !bus_req)) else $error("AST_LOAD_STALL"); // R7

endmodule

// File: rtl/fixed_imem.sv
module fixed_imem
    import fim_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned MEM_BYTES = 4096,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0000_8000,
    localparam int unsigned OFS_W = fim_ofs_bits(DATA_W),
    localparam int unsigned IDX_W = fim_idx_bits(MEM_BYTES, DATA_W),
    localparam int unsigned WIN_AW = IDX_W + OFS_W,
    localparam int unsigned DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic [DATA_W-1:0] fetch_data,
    output logic              fetch_ready,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  load_addr,
    input  logic [DATA_W-1:0] load_data
);
    logic              in_range;
    logic              rd_en;
    logic [DATA_W-1:0] ram_word;
    logic [DATA_W-1:0] bus_word;
    fim_resp_t         resp;

    fim_range_check #(
        .ADDR_W    (ADDR_W),
        .WIN_AW    (WIN_AW),
        .BASE_ADDR (BASE_ADDR)
    ) u_range (
        .addr     (fetch_addr),
        .in_range (in_range)
    );

    fim_ram #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_ram (
        .clk     (clk),
        .wr_en   (load_en),
        .wr_idx  (load_addr),
        .wr_data (load_data),
        .rd_en   (rd_en),
        .rd_idx  (fetch_addr[WIN_AW-1:OFS_W]),
        .rd_data (ram_word)
    );

    fim_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .in_range   (in_range),
        .load_busy  (load_en),
        .bus_ack    (bus_ack),
        .bus_data   (bus_data),
        .bus_req    (bus_req),
        .bus_addr   (bus_addr),
        .rd_en      (rd_en),
        .resp       (resp),
        .bus_word   (bus_word)
    );

    assign fetch_ready = resp.ready;
    assign fetch_data  = (resp.src == SRC_BUS) ? bus_word : ram_word;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!fetch_ready && !bus_req)) else $error("AST_RESET_QUIET"); // R1

    AST_HIT_READY: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && in_range && !load_en && !bus_req) |=> (fetch_ready && !bus_req)) else $error("AST_HIT_READY"); // R2

    AST_BUS_DATA: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ack) |=> (fetch_data == $past(bus_data))) else $error("AST_BUS_DATA"); // R5

endmodule

// File: tb/fixed_imem_tb.sv
module fixed_imem_tb;
    localparam int unsigned AW    = 16;
    localparam int unsigned DW    = 32;
    localparam int unsigned MB    = 256;
    localparam int unsigned WORDS = MB / 4;
    localparam logic [AW-1:0] BASE = 16'h0400;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fetch_req = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic [DW-1:0] fetch_data;
    logic          fetch_ready;
    logic          bus_req;
    logic [AW-1:0] bus_addr;
    logic          bus_ack = 1'b0;
    logic [DW-1:0] bus_data = '0;
    logic          load_en = 1'b0;
    logic [5:0]    load_addr = '0;
    logic [DW-1:0] load_data = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fixed_imem #(
        .ADDR_W    (AW),
        .DATA_W    (DW),
        .MEM_BYTES (MB),
        .BASE_ADDR (BASE)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .fetch_data  (fetch_data),
        .fetch_ready (fetch_ready),
        .bus_req     (bus_req),
        .bus_addr    (bus_addr),
        .bus_ack     (bus_ack),
        .bus_data    (bus_data),
        .load_en     (load_en),
        .load_addr   (load_addr),
        .load_data   (load_data)
    );

    function automatic logic [DW-1:0] ram_val(input int i);
        return (i * 32'h9E37_79B1) + 32'h0000_1234;
    endfunction

    function automatic logic [DW-1:0] bus_val(input logic [AW-1:0] a);
        return {a, ~a};
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Out-of-window fetch with w wait cycles on the bus
    task automatic do_miss(input logic [AW-1:0] a, input int w);
        @(negedge clk);
        fetch_req  = 1'b1;
        fetch_addr = a;
        @(negedge clk);
        chk("R4 bus_req", {31'd0, bus_req}, 32'd1);
        chk("R4 bus_addr", {16'd0, bus_addr}, {16'd0, a});
        chk("R4 ready low", {31'd0, fetch_ready}, 32'd0);
        fetch_addr = a ^ 16'h0040;
        for (int k = 0; k < w; k++) begin
            @(negedge clk);
            chk("R9 bus_addr held", {16'd0, bus_addr}, {16'd0, a});
            chk("R4 still waiting", {30'd0, bus_req, fetch_ready}, 32'd2);
        end
        bus_ack  = 1'b1;
        bus_data = bus_val(a);
        @(negedge clk);
        chk("R5 ready", {31'd0, fetch_ready}, 32'd1);
        chk("R5 data", fetch_data, bus_val(a));
        chk("R5 bus_req low", {31'd0, bus_req}, 32'd0);
        bus_ack   = 1'b0;
        bus_data  = 32'hDEAD_BEEF;
        fetch_req = 1'b0;
        @(negedge clk);
        chk("R5 single ready", {31'd0, fetch_ready}, 32'd0);
    endtask

    // Single in-window fetch of word i
    task automatic do_hit(input int i, input logic [DW-1:0] exp, input string req);
        @(negedge clk);
        fetch_req  = 1'b1;
        fetch_addr = BASE + AW'(i * 4);
        @(negedge clk);
        fetch_req = 1'b0;
        chk(req, {31'd0, fetch_ready}, 32'd1);
        chk(req, fetch_data, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", {31'd0, fetch_ready}, 32'd0);
        chk("R1 bus_req in reset", {31'd0, bus_req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", {30'd0, fetch_ready, bus_req}, 32'd0);

        // R6: fill the whole window
        for (int i = 0; i < WORDS; i++) begin
            @(negedge clk);
            load_en   = 1'b1;
            load_addr = 6'(i);
            load_data = ram_val(i);
        end
        @(negedge clk);
        load_en = 1'b0;

        // R2, R3, R8: back-to-back sweep with varying byte offsets
        for (int i = 0; i <= WORDS; i++) begin
            @(negedge clk);
            if (i > 0) begin
                chk("R2 ready", {31'd0, fetch_ready}, 32'd1);
                chk("R2 R8 data", fetch_data, ram_val(i - 1));
                chk("R3 no bus", {31'd0, bus_req}, 32'd0);
            end
            if (i < WORDS) begin
                fetch_req  = 1'b1;
                fetch_addr = BASE + AW'(i * 4) + AW'(i % 4);
            end else begin
                fetch_req = 1'b0;
            end
        end
        @(negedge clk);
        chk("R2 idle no ready", {31'd0, fetch_ready}, 32'd0);

        // R4, R5, R9: window edges and extremes, varied bus latency
        do_miss(16'h03FC, 0);
        do_miss(16'h0500, 1);
        do_miss(16'h0000, 2);
        do_miss(16'hFFFF, 3);
        do_miss(16'h8400, 1);
        do_hit(WORDS - 1, ram_val(WORDS - 1), "R2 last word");
        do_hit(0, ram_val(0), "R2 first word");

        // R7: in-window fetch during load; R6: last write wins
        @(negedge clk);
        load_en    = 1'b1;
        load_addr  = 6'd5;
        load_data  = 32'h1111_2222;
        fetch_req  = 1'b1;
        fetch_addr = BASE + 16'd20;
        @(negedge clk);
        chk("R7 stall ready", {31'd0, fetch_ready}, 32'd0);
        chk("R7 stall bus", {31'd0, bus_req}, 32'd0);
        load_data = 32'h3333_4444;
        @(negedge clk);
        chk("R7 stall ready 2", {31'd0, fetch_ready}, 32'd0);
        load_en = 1'b0;
        @(negedge clk);
        fetch_req = 1'b0;
        chk("R7 served after load", {31'd0, fetch_ready}, 32'd1);
        chk("R6 last write", fetch_data, 32'h3333_4444);

        // R7: out-of-window fetch during load
        @(negedge clk);
        load_en    = 1'b1;
        load_addr  = 6'd9;
        load_data  = 32'h5555_6666;
        fetch_req  = 1'b1;
        fetch_addr = 16'h0600;
        @(negedge clk);
        chk("R7 miss stall bus", {31'd0, bus_req}, 32'd0);
        chk("R7 miss stall ready", {31'd0, fetch_ready}, 32'd0);
        load_en = 1'b0;
        @(negedge clk);
        chk("R7 miss after load", {31'd0, bus_req}, 32'd1);
        bus_ack  = 1'b1;
        bus_data = bus_val(16'h0600);
        @(negedge clk);
        bus_ack   = 1'b0;
        fetch_req = 1'b0;
        chk("R7 miss served", fetch_data, bus_val(16'h0600));
        do_hit(9, 32'h5555_6666, "R6 loaded word");
        do_hit(8, ram_val(8), "R6 neighbour untouched");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule